// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Port

This block sits between an interrupt distributor and one processor core. Every clock it receives the pending state, trigger type and priority of each interrupt ID routed to this core, plus the originating core of each software interrupt. It selects the most urgent eligible ID and raises a single request line toward the core.

The core talks to the port through a small register bus with four words: an enable control, a priority threshold, an acknowledge word and an end-of-service word. Reading the acknowledge word hands out the ID to service and marks it in service. Writing the end-of-service word retires it. One running-priority register remembers the urgency of the last acknowledged ID, so only a more urgent source can interrupt the core while it is busy.

Top module: `irq_cpu_port`

## Requirements
- R1: The acknowledge word carries the interrupt ID in bits 9:0. For IDs 0 to 15 (software interrupts), bits 12:10 carry that ID's originating core number. For every other ID, bits 12:10 are zero. Bits 31:13 are always zero.
- R2: Reading the acknowledge word when no ID is eligible returns 1023, the spurious value, and changes no state.
- R3: Writing an ID to the end-of-service word clears that ID's in-service state and frees the running priority. Bits above 9 of the written value are ignored, so the full acknowledge value may be written back. A value that is not an in-service ID, including the reserved values 1021 to 1023, has no effect.
- R4: An ID is eligible only if its priority value is numerically below the threshold word.
- R5: Bit 0 of the control word gates signalling. While it is 0, the request line stays low and acknowledge returns 1023.
- R6: Among eligible IDs, the lowest priority value wins. On a tie, the lowest ID wins.
- R7: Acknowledging an edge-type ID clears its latched pending bit. Any acknowledged ID becomes in service and is not presented again until its end-of-service write. A level-type ID whose input is still high is presented again after that write. An edge pulse that arrives while the ID is in service stays latched.
- R8: Acknowledge loads the running priority with the chosen ID's priority. While it is held, only a strictly lower priority value raises the request line.
- R9: Source inputs are captured on a clock edge. The request line is a register that follows captured or register state one edge later. Read data appears, with a valid strobe, in the cycle after the read strobe.
- R10: The bus uses word index 0 for control (bit 0 only), 1 for the threshold (low PRIO_W bits), 2 for acknowledge and 3 for end-of-service. Control and threshold reset to 0 and read back what was stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src_pend_i | input | NUM_IRQ | Per-ID pending: a level for level-type IDs, a one-cycle pulse for edge-type IDs |
| src_edge_i | input | NUM_IRQ | Per-ID trigger type, 1 = edge |
| src_prio_i | input | NUM_IRQ*PRIO_W | Per-ID priority value, ID n in bits n*PRIO_W upward |
| sgi_src_i | input | 16*3 | Originating core of each software interrupt ID |
| bus_rd_i | input | 1 | Read strobe |
| bus_wr_i | input | 1 | Write strobe |
| bus_addr_i | input | 2 | Word index |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| bus_rvalid_o | output | 1 | Read data valid |
| irq_o | output | 1 | Interrupt request to the core |

## Verification
The bench builds the port with 40 IDs and 8-bit priorities. This covers all three ID classes (software, private, shared), keeps the arbiter small, and leaves end-of-service values from 40 up to 1020 that name no ID at all. The 8-bit priority lets the threshold boundary be hit exactly at 0xF0 against 0xEF. Stimulus mixes level and edge sources, so the priority ties, the running-priority blocking and the re-presentation after end-of-service can each be reached.

// File: rtl/irq_cpu_pkg.sv
package irq_cpu_pkg;
   localparam int ID_W     = 10;
   localparam int SRC_W    = 3;
   localparam int DATA_W   = 32;
   localparam int NUM_SGI  = 16;
   localparam logic [ID_W-1:0] ID_SPURIOUS = 10'd1023;

   typedef enum logic [1:0] {
      RS_CTRL  = 2'd0,
      RS_PMASK = 2'd1,
      RS_ACK   = 2'd2,
      RS_EOI   = 2'd3
   } reg_sel_e;
endpackage

// File: rtl/irq_cpu_pend.sv
// Per-ID pending capture: edge IDs latch pulses until acknowledged,
// level IDs follow their input one edge late.
module irq_cpu_pend #(
   parameter int NUM_IRQ = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_IRQ-1:0] src_pend_i,
   input  logic [NUM_IRQ-1:0] src_edge_i,
   input  logic [NUM_IRQ-1:0] clr_i,
   output logic [NUM_IRQ-1:0] pend_o
);
   for (genvar g = 0; g < NUM_IRQ; g++) begin : g_id
      logic bit_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            bit_q <= 1'b0;
         else if (src_edge_i[g])
            bit_q <= (bit_q & ~clr_i[g]) | src_pend_i[g];
         else
            bit_q <= src_pend_i[g];
      end
      assign pend_o[g] = bit_q;
   end
endmodule

// File: rtl/irq_cpu_arb.sv
// Lowest priority value wins; ascending scan keeps the lowest ID on a tie.
module irq_cpu_arb #(
   parameter int NUM_IRQ = 64,
   parameter int PRIO_W  = 8,
   localparam int IDX_W  = $clog2(NUM_IRQ)
) (
   input  logic [NUM_IRQ-1:0]        elig_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
   output logic                      vld_o,
   output logic [IDX_W-1:0]          idx_o,
   output logic [PRIO_W-1:0]         prio_o
);
   always_comb begin
      vld_o  = 1'b0;
      idx_o  = '0;
      prio_o = '1;
      for (int i = 0; i < NUM_IRQ; i++) begin
         if (elig_i[i] && (!vld_o || prio_i[i*PRIO_W +: PRIO_W] < prio_o)) begin
            vld_o  = 1'b1;
            idx_o  = IDX_W'(i);
            prio_o = prio_i[i*PRIO_W +: PRIO_W];
         end
      end
   end
endmodule

// File: rtl/irq_cpu_port.sv
module irq_cpu_port
   import irq_cpu_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   parameter int PRIO_W  = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [NUM_IRQ-1:0]        src_pend_i,
   input  logic [NUM_IRQ-1:0]        src_edge_i,
   input  logic [NUM_IRQ*PRIO_W-1:0] src_prio_i,
   input  logic [NUM_SGI*SRC_W-1:0]  sgi_src_i,
   input  logic                      bus_rd_i,
   input  logic                      bus_wr_i,
   input  logic [1:0]                bus_addr_i,
   input  logic [DATA_W-1:0]         bus_wdata_i,
   output logic [DATA_W-1:0]         bus_rdata_o,
   output logic                      bus_rvalid_o,
   output logic                      irq_o
);
   localparam int IDX_W = $clog2(NUM_IRQ);

   if (NUM_IRQ <= NUM_SGI || NUM_IRQ > 1020) begin : g_bad_num
      $error("irq_cpu_port: NUM_IRQ must lie in 17..1020");
   end
   if (PRIO_W < 2 || PRIO_W > 8) begin : g_bad_prio
      $error("irq_cpu_port: PRIO_W must lie in 2..8");
   end

   logic                en_q;
   logic [PRIO_W-1:0]   pmask_q;
   logic [PRIO_W-1:0]   run_q;
   logic                run_vld_q;
   logic [NUM_IRQ-1:0]  act_q;
   logic [NUM_IRQ-1:0]  pend;
   logic [NUM_IRQ-1:0]  clr_vec;
   logic                best_vld;
   logic [IDX_W-1:0]    best_idx;
   logic [PRIO_W-1:0]   best_prio;
   logic                take;
   logic                ack_rd, ack_hit;
   logic                eoi_wr, eoi_hit;
   logic [ID_W-1:0]     eoi_id;
   logic [IDX_W-1:0]    eoi_idx;
   logic [SRC_W-1:0]    best_src;
   logic [DATA_W-1:0]   rd_mux;
   logic                unused_wdata;

   assign unused_wdata = ^bus_wdata_i[DATA_W-1:ID_W];

   irq_cpu_pend #(.NUM_IRQ(NUM_IRQ)) u_pend (
      .clk        (clk),
      .rst_n      (rst_n),
      .src_pend_i (src_pend_i),
      .src_edge_i (src_edge_i),
      .clr_i      (clr_vec),
      .pend_o     (pend)
   );

   irq_cpu_arb #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_arb (
      .elig_i (pend & ~act_q),
      .prio_i (src_prio_i),
      .vld_o  (best_vld),
      .idx_o  (best_idx),
      .prio_o (best_prio)
   );

   // Gate the winner by enable, threshold and running priority.
   assign take = best_vld && en_q && (best_prio < pmask_q)
                 && (!run_vld_q || best_prio < run_q);

   assign ack_rd  = bus_rd_i && (bus_addr_i == RS_ACK);
   assign ack_hit = ack_rd && take;
   assign eoi_wr  = bus_wr_i && (bus_addr_i == RS_EOI);
   assign eoi_id  = bus_wdata_i[ID_W-1:0];
   assign eoi_idx = eoi_id[IDX_W-1:0];
   assign eoi_hit = eoi_wr && (eoi_id < ID_W'(NUM_IRQ)) && act_q[eoi_idx];

   always_comb begin
      clr_vec = '0;
      if (ack_hit) clr_vec[best_idx] = 1'b1;
   end

   assign best_src = (best_idx < IDX_W'(NUM_SGI))
                     ? sgi_src_i[int'(best_idx[3:0])*SRC_W +: SRC_W] : '0;

   always_comb begin
      rd_mux = '0;
      unique case (bus_addr_i)
         RS_CTRL:  rd_mux[0] = en_q;
         RS_PMASK: rd_mux[PRIO_W-1:0] = pmask_q;
         RS_ACK:   rd_mux[ID_W+SRC_W-1:0] = take ? {best_src, ID_W'(best_idx)}
                                                 : {{SRC_W{1'b0}}, ID_SPURIOUS};
         default:  rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q         <= 1'b0;
         pmask_q      <= '0;
         run_q        <= '0;
         run_vld_q    <= 1'b0;
         act_q        <= '0;
         irq_o        <= 1'b0;
         bus_rdata_o  <= '0;
         bus_rvalid_o <= 1'b0;
      end else begin
         irq_o        <= take;
         bus_rvalid_o <= bus_rd_i;
         if (bus_rd_i) bus_rdata_o <= rd_mux;
         if (bus_wr_i && bus_addr_i == RS_CTRL)  en_q    <= bus_wdata_i[0];
         if (bus_wr_i && bus_addr_i == RS_PMASK) pmask_q <= bus_wdata_i[PRIO_W-1:0];
         if (ack_hit) begin
            act_q[best_idx] <= 1'b1;
            run_q           <= best_prio;
            run_vld_q       <= 1'b1;
         end else if (eoi_hit) begin
            act_q[eoi_idx]  <= 1'b0;
            run_vld_q       <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/irq_cpu_port_chk.sv
module irq_cpu_port_chk
   import irq_cpu_pkg::*;
#(
   parameter int NUM_IRQ = 64,
   localparam int IDX_W  = $clog2(NUM_IRQ)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               en_q,
   input logic [NUM_IRQ-1:0] act_q,
   input logic               bus_rd_i,
   input logic               bus_wr_i,
   input logic [1:0]         bus_addr_i,
   input logic [DATA_W-1:0]  bus_wdata_i,
   input logic [DATA_W-1:0]  bus_rdata_o,
   input logic               bus_rvalid_o,
   input logic               irq_o
);
   p_off_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !en_q |=> !irq_o);

   p_ack_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i == RS_ACK) |=>
      (bus_rdata_o[ID_W-1:0] == ID_SPURIOUS || bus_rdata_o[ID_W-1:0] < ID_W'(NUM_IRQ)));

   p_ack_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i == RS_ACK) |=>
      (bus_rdata_o[DATA_W-1:ID_W+SRC_W] == '0 &&
       (bus_rdata_o[ID_W-1:0] < ID_W'(NUM_SGI) || bus_rdata_o[ID_W+SRC_W-1:ID_W] == '0)));

   p_ack_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd_i && bus_addr_i == RS_ACK) |=>
      (bus_rdata_o[ID_W-1:0] >= ID_W'(NUM_IRQ) || act_q[bus_rdata_o[IDX_W-1:0]]));

   p_eoi_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr_i && !bus_rd_i && bus_addr_i == RS_EOI && bus_wdata_i[ID_W-1:0] < ID_W'(NUM_IRQ))
      |=> !act_q[$past(bus_wdata_i[IDX_W-1:0])]);

   p_rvalid_r9: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd_i |=> bus_rvalid_o);

   p_rvalid_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_rd_i |=> !bus_rvalid_o);
endmodule

bind irq_cpu_port irq_cpu_port_chk #(.NUM_IRQ(NUM_IRQ)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .en_q         (en_q),
   .act_q        (act_q),
   .bus_rd_i     (bus_rd_i),
   .bus_wr_i     (bus_wr_i),
   .bus_addr_i   (bus_addr_i),
   .bus_wdata_i  (bus_wdata_i),
   .bus_rdata_o  (bus_rdata_o),
   .bus_rvalid_o (bus_rvalid_o),
   .irq_o        (irq_o)
);

// File: tb/irq_cpu_port_tb_top.sv
`timescale 1ns/1ps
module irq_cpu_port_tb_top;
   localparam int N  = 40;
   localparam int PW = 8;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    src_pend = '0;
   logic [N-1:0]    src_edge = '0;
   logic [N*PW-1:0] src_prio = '0;
   logic [47:0]     sgi_src = '0;
   logic            bus_rd = 1'b0, bus_wr = 1'b0;
   logic [1:0]      bus_addr = '0;
   logic [31:0]     bus_wdata = '0;
   logic [31:0]     bus_rdata;
   logic            bus_rvalid;
   logic            irq;

   int checks = 0;
   int errors = 0;
   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   irq_cpu_port #(.NUM_IRQ(N), .PRIO_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n),
      .src_pend_i(src_pend), .src_edge_i(src_edge), .src_prio_i(src_prio),
      .sgi_src_i(sgi_src),
      .bus_rd_i(bus_rd), .bus_wr_i(bus_wr), .bus_addr_i(bus_addr),
      .bus_wdata_i(bus_wdata), .bus_rdata_o(bus_rdata),
      .bus_rvalid_o(bus_rvalid), .irq_o(irq)
   );

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic wait_c(input int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic chk_irq(input logic e, input string tag);
      checks++;
      if (irq !== e) begin
         errors++;
         $display("FAIL %s irq actual %0b expected %0b", tag, irq, e);
      end
   endtask

   // Driver: queue the expectation, then issue the read.
   task automatic rd(input logic [1:0] a, input logic [31:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_rd = 1'b1; bus_addr = a;
      tick();
      bus_rd = 1'b0;
   endtask

   task automatic wr(input logic [1:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      tick();
      bus_wr = 1'b0;
   endtask

   task automatic set_prio(input int id, input logic [PW-1:0] p);
      src_prio[id*PW +: PW] = p;
   endtask

   task automatic pulse(input int id);
      src_pend[id] = 1'b1;
      tick();
      src_pend[id] = 1'b0;
   endtask

   // Monitor: compare every returned read against the queue head.
   always @(negedge clk) begin
      if (rst_n && bus_rvalid) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL unexpected read data actual %h expected none", bus_rdata);
         end else begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (bus_rdata !== e) begin
               errors++;
               $display("FAIL %s rdata actual %h expected %h", t, bus_rdata, e);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < N; i++) set_prio(i, 8'h80);
      sgi_src[10*3 +: 3] = 3'd5;
      sgi_src[5*3 +: 3]  = 3'd2;
      wait_c(3);
      rst_n = 1'b1;
      tick();

      // Reset state
      chk_irq(1'b0, "R10 reset irq");
      rd(2'd0, 32'h0, "R10 reset ctrl");
      rd(2'd1, 32'h0, "R10 reset threshold");

      // Register map and stored widths
      wr(2'd1, 32'h1F0);
      wr(2'd0, 32'hFFFF_FFFE);
      rd(2'd0, 32'h0, "R10 ctrl bit0 only");
      rd(2'd1, 32'hF0, "R10 threshold width");
      wr(2'd0, 32'h1);
      rd(2'd0, 32'h1, "R10 ctrl readback");

      // Nothing pending
      rd(2'd2, 32'd1023, "R2 spurious when idle");

      // Level ID, latency
      set_prio(35, 8'h80);
      src_pend[35] = 1'b1;
      tick();
      chk_irq(1'b0, "R9 one edge after input");
      tick();
      chk_irq(1'b1, "R9 two edges after input");
      rd(2'd2, 32'd35, "R1 shared ID no source");
      wait_c(2);
      chk_irq(1'b0, "R7 in-service not re-presented");
      wr(2'd3, 32'd35);
      wait_c(2);
      chk_irq(1'b1, "R7 level re-presented after retire");
      rd(2'd2, 32'd35, "R7 level second ack");
      src_pend[35] = 1'b0;
      wr(2'd3, 32'd35);
      wait_c(3);
      chk_irq(1'b0, "R7 level dropped");

      // Threshold boundary
      set_prio(36, 8'hF0);
      src_pend[36] = 1'b1;
      wait_c(3);
      chk_irq(1'b0, "R4 equal to threshold");
      rd(2'd2, 32'd1023, "R4 equal to threshold ack");
      set_prio(36, 8'hEF);
      wait_c(3);
      chk_irq(1'b1, "R4 just below threshold");
      rd(2'd2, 32'd36, "R4 below threshold ack");
      src_pend[36] = 1'b0;
      wr(2'd3, 32'd36);
      wait_c(3);

      // Arbitration and running priority
      set_prio(33, 8'h40); set_prio(20, 8'h40); set_prio(38, 8'h10);
      src_pend[33] = 1'b1; src_pend[20] = 1'b1; src_pend[38] = 1'b1;
      wait_c(3);
      rd(2'd2, 32'd38, "R6 lowest value wins");
      wait_c(2);
      chk_irq(1'b0, "R8 less urgent blocked");
      rd(2'd2, 32'd1023, "R8 less urgent ack spurious");
      src_pend[38] = 1'b0;
      wr(2'd3, 32'd38);
      wait_c(3);
      rd(2'd2, 32'd20, "R6 tie lowest ID");
      src_pend[20] = 1'b0;
      wait_c(3);
      chk_irq(1'b0, "R8 equal priority blocked");
      wr(2'd3, 32'd20);
      wait_c(3);
      rd(2'd2, 32'd33, "R6 remaining ID");
      wait_c(2);

      // Software interrupt, edge type, strictly more urgent
      src_edge[10] = 1'b1;
      set_prio(10, 8'h20);
      pulse(10);
      wait_c(3);
      chk_irq(1'b1, "R8 more urgent raises line");
      rd(2'd2, 32'h0000_140A, "R1 software ID with source core");
      wait_c(2);
      chk_irq(1'b0, "R7 edge in service");
      wr(2'd3, 32'h0000_140A);
      wait_c(3);
      chk_irq(1'b0, "R7 edge pending consumed");
      src_pend[33] = 1'b0;
      wr(2'd3, 32'd33);
      wait_c(3);
      rd(2'd2, 32'd1023, "R3 all retired");

      // Ignored end-of-service values, pulse during service
      src_edge[5] = 1'b1;
      set_prio(5, 8'h30);
      pulse(5);
      wait_c(3);
      rd(2'd2, 32'h0000_0805, "R1 second software ID");
      wait_c(2);
      pulse(5);
      wait_c(3);
      chk_irq(1'b0, "R7 pulse held while in service");
      wr(2'd3, 32'd1023);
      wr(2'd3, 32'd39);
      wait_c(3);
      chk_irq(1'b0, "R3 reserved and idle IDs ignored");
      rd(2'd2, 32'd1023, "R3 ID still in service");
      wr(2'd3, 32'h0000_0805);
      wait_c(3);
      chk_irq(1'b1, "R7 latched pulse presented");
      rd(2'd2, 32'h0000_0805, "R7 latched pulse ack");
      wr(2'd3, 32'd5);
      wait_c(3);
      chk_irq(1'b0, "R3 retire via bare ID");

      // Control gate
      set_prio(32, 8'h50);
      src_pend[32] = 1'b1;
      wr(2'd0, 32'h0);
      wait_c(3);
      chk_irq(1'b0, "R5 disabled line low");
      rd(2'd2, 32'd1023, "R5 disabled ack spurious");
      wr(2'd0, 32'h1);
      wait_c(3);
      chk_irq(1'b1, "R5 enabled line high");
      rd(2'd2, 32'd32, "R5 enabled ack");
      src_pend[32] = 1'b0;
      wr(2'd3, 32'd32);
      wait_c(3);
      chk_irq(1'b0, "R3 final idle");

      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL R9 reads outstanding actual %0d expected 0", exp_q.size());
      end
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule